// File: doc/BRIEF.md
# Dual ADC Conversion Controller

This block sequences a pair of 10-bit analog-to-digital converter units that work side by side. Each unit converts one of eight inputs, picked by a 3-bit channel field, so sixteen inputs are reachable across the pair. The block decides when conversions begin and drives a start pulse, a busy indication and a channel select to each converter. It takes back a done pulse with a 10-bit result. Results go into a two-entry FIFO per unit, and an end-of-conversion flag drives an interrupt line.

Software programs a shadow copy of the control word at any time. The shadow is moved into the active copy only when neither unit is converting, so the channel selects and modes never change under a running conversion. A conversion round can be started by a software command, by a synchronized edge on an external pin (polarity selectable), or by any of several event lines from a timer/capture block. Enabled units start together. A mode bit makes the units restart after every round. A policy bit decides whether a request that arrives during a round aborts the round and restarts at once, or is held until the round completes.

Top module: `dual_conv_ctrl`

## Requirements
- R1: After reset, conv_start, conv_busy, ovf, int_flag and irq are all 0, and both rd_empty bits are 1.
- R2: Control word fields: ch0 [2:0], ch1 [5:3], continuous [6], immediate [7], irq enable [8], falling-edge select [9], software-trigger enable [10], pin-trigger enable [11], event-trigger enable [12], unit0 enable [13], unit1 enable [14]. Command word: [0] start, [1] clear interrupt flag, [2] clear unit0 overflow, [3] clear unit1 overflow. A command start, with software triggering enabled and the units idle, pulses conv_start for all enabled units in the cycle after the command, while conv_ch = {ch1, ch0}. With software triggering disabled the command starts nothing.
- R3: In continuous mode, a round restarts after every completion once triggered. With continuous clear, each trigger gives exactly one round.
- R4: Each unit keeps results in a FIFO two entries deep, read oldest first. A pop loads rd_data on the next clock. Popping an empty FIFO leaves rd_data unchanged, and rd_empty reads 1.
- R5: A result that arrives when its FIFO is full, with no pop in that cycle, is dropped. The stored entries are kept, and that unit's ovf bit sets and stays set until its clear command bit is written.
- R6: A control word write reaches the active settings (conv_ch and the modes) only while no unit is busy. conv_ch stays stable during a conversion.
- R7: With immediate clear, a trigger during a round is held and starts a new round after the round ends, so no start occurs while busy. With immediate set, a trigger during a round starts a new round in the next cycle, and the abandoned conversion yields no result.
- R8: The external pin passes through a two-stage synchronizer and triggers on a rising edge (field [9] = 0) or a falling edge ([9] = 1). The opposite edge starts nothing, and the pin has no effect while its enable is clear.
- R9: A one-cycle pulse on any ev_trig line, with event triggering enabled, starts the enabled units in the next cycle. The lines are ignored while the enable is clear.
- R10: int_flag sets on every accepted result and stays set until command bit [1] clears it. irq equals int_flag gated by the irq enable field.
- R11: A conv_done pulse for a unit that is not busy is ignored: no FIFO write and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the shadow control word |
| ctl_wdata | input | 15 | Control word value |
| cmd_wr | input | 1 | Command strobe |
| cmd_wdata | input | 4 | Command bits (start, clear flag, clear overflows) |
| ext_pin | input | 1 | Asynchronous external trigger pin |
| ev_trig | input | EV_W | Event pulses from timer/capture logic |
| conv_start | output | 2 | One-cycle start pulse per converter |
| conv_busy | output | 2 | Unit conversion in progress |
| conv_ch | output | 6 | Channel selects, unit1 in [5:3], unit0 in [2:0] |
| conv_done | input | 2 | Conversion finished pulse per converter |
| conv_data | input | 20 | Results, unit1 in [19:10], unit0 in [9:0] |
| rd_pop | input | 2 | FIFO read strobe per unit |
| rd_data | output | 20 | Last popped result per unit |
| rd_empty | output | 2 | FIFO holds no entry |
| ovf | output | 2 | Sticky overflow per unit |
| int_flag | output | 1 | Sticky end-of-conversion flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the moments when a control write or a trigger arrives in the middle of a round. A design that applied the shadow at once would show a new channel on conv_ch while busy. A design with the wrong start policy would either pulse a start during a waiting round or lose the held request. The FIFO is filled past its depth and read when empty. A design that overwrote the oldest entry, or returned garbage on an empty read, would return the wrong sequence numbers. The opposite pin edge, disabled sources and a stray done pulse are driven too, because a design that acted on them would add starts, FIFO entries or interrupt flags.

// File: rtl/dconv_pkg.sv
package dconv_pkg;

    localparam int N_UNITS    = 2;
    localparam int CH_W       = 3;
    localparam int DATA_W     = 10;
    localparam int EV_W       = 4;
    localparam int FIFO_DEPTH = 2;
    localparam int CMD_W      = 4;

    localparam int CMD_START    = 0;
    localparam int CMD_CLR_INT  = 1;
    localparam int CMD_CLR_OVF0 = 2;

    typedef struct packed {
        logic            u1_en;
        logic            u0_en;
        logic            ev_en;
        logic            ext_en;
        logic            sw_en;
        logic            ext_fall;
        logic            irq_en;
        logic            immediate;
        logic            continuous;
        logic [CH_W-1:0] ch1;
        logic [CH_W-1:0] ch0;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    function automatic logic edge_hit(logic cur, logic prev, logic fall);
        return fall ? (!cur && prev) : (cur && !prev);
    endfunction

endpackage

// File: rtl/dconv_trig.sv
module dconv_trig
    import dconv_pkg::*;
#(
    parameter int EV_LINES = EV_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ext_pin,
    input  logic [EV_LINES-1:0] ev_trig,
    input  logic                sw_req,
    input  ctl_t                ctl,
    output logic                trig
);

    logic [1:0] sync_q;
    logic       prev_q;
    logic       pin_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_pin};
            prev_q <= sync_q[1];
        end
    end

    assign pin_hit = edge_hit(sync_q[1], prev_q, ctl.ext_fall);

    assign trig = (ctl.sw_en  && sw_req)
               || (ctl.ext_en && pin_hit)
               || (ctl.ev_en  && (|ev_trig));

endmodule

// File: rtl/dconv_seq.sv
module dconv_seq
    import dconv_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ctl_wr,
    input  ctl_t               ctl_wdata,
    input  logic               trig,
    input  logic               clr_int,
    input  logic [N_UNITS-1:0] conv_done,
    output ctl_t               act,
    output logic [N_UNITS-1:0] conv_start,
    output logic [N_UNITS-1:0] busy,
    output logic [N_UNITS-1:0] push,
    output logic               int_flag,
    output logic               irq
);

    ctl_t               shadow_q, act_q;
    logic               shdw_pend_q;
    logic [N_UNITS-1:0] busy_q, start_q, accept, unit_mask;
    logic               pend_q, run_q, flag_q;
    logic               idle, load_now, want, start_now;

    assign unit_mask = {act_q.u1_en, act_q.u0_en};
    assign idle      = (busy_q == '0);
    assign load_now  = idle && shdw_pend_q;
    assign want      = trig || pend_q || (act_q.continuous && run_q);
    assign start_now = (unit_mask != '0)
                    && ((idle && !shdw_pend_q && want)
                     || (!idle && act_q.immediate && trig));
    assign accept    = conv_done & busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q    <= '0;
            act_q       <= '0;
            shdw_pend_q <= 1'b0;
            busy_q      <= '0;
            start_q     <= '0;
            pend_q      <= 1'b0;
            run_q       <= 1'b0;
            flag_q      <= 1'b0;
        end else begin
            if (load_now) begin
                act_q       <= shadow_q;
                shdw_pend_q <= 1'b0;
            end
            if (ctl_wr) begin
                shadow_q    <= ctl_wdata;
                shdw_pend_q <= 1'b1;
            end

            start_q <= start_now ? unit_mask : '0;
            busy_q  <= (busy_q & ~accept) | (start_now ? unit_mask : '0);

            if (start_now)
                pend_q <= 1'b0;
            else if (trig)
                pend_q <= 1'b1;

            if (start_now)
                run_q <= act_q.continuous;
            else if (load_now)
                run_q <= run_q && shadow_q.continuous;

            if (accept != '0)
                flag_q <= 1'b1;
            else if (clr_int)
                flag_q <= 1'b0;
        end
    end

    assign act        = act_q;
    assign conv_start = start_q;
    assign busy       = busy_q;
    assign push       = accept;
    assign int_flag   = flag_q;
    assign irq        = flag_q && act_q.irq_en;

    // R6: the active settings cannot move between two busy cycles
    p_ch_stable_r6: assert property (@(posedge clk) disable iff (rst)
        ((|busy_q) && $past(|busy_q)) |-> $stable(act_q));

    // R7: hold policy never starts while a round is running
    p_wait_policy_r7: assert property (@(posedge clk) disable iff (rst)
        ((|busy_q) && !act_q.immediate) |=> (start_q == '0));

    // R10: the flag is sticky until cleared
    p_flag_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !clr_int) |=> flag_q);

endmodule

// File: rtl/dconv_fifo.sv
module dconv_fifo
    import dconv_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             clr_ovf,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_empty,
    output logic             ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [PTR_W-1:0] rd_ptr_q, wr_ptr_q;
    logic [CNT_W-1:0] cnt_q;
    logic [WIDTH-1:0] data_q;
    logic             ovf_q;
    logic             empty, full, do_pop, do_push;

    function automatic logic [PTR_W-1:0] nxt(logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_ptr_q <= '0;
            wr_ptr_q <= '0;
            cnt_q    <= '0;
            data_q   <= '0;
            ovf_q    <= 1'b0;
        end else begin
            if (do_push) begin
                mem_q[wr_ptr_q] <= push_data;
                wr_ptr_q        <= nxt(wr_ptr_q);
            end
            if (do_pop) begin
                data_q   <= mem_q[rd_ptr_q];
                rd_ptr_q <= nxt(rd_ptr_q);
            end
            if (do_push && !do_pop)
                cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push)
                cnt_q <= cnt_q - 1'b1;

            if (push && !do_push)
                ovf_q <= 1'b1;
            else if (clr_ovf)
                ovf_q <= 1'b0;
        end
    end

    assign rd_data  = data_q;
    assign rd_empty = empty;
    assign ovf      = ovf_q;

    // R5: a result refused by a full FIFO raises the overflow bit
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> ovf_q);

    // R4: occupancy never exceeds the depth
    p_level_bound_r4: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(DEPTH));

    // R4: an empty read leaves the read data untouched
    p_empty_read_r4: assert property (@(posedge clk) disable iff (rst)
        (pop && empty) |=> $stable(data_q));

endmodule

// File: rtl/dual_conv_ctrl.sv
module dual_conv_ctrl
    import dconv_pkg::*;
#(
    parameter int RES_W    = DATA_W,
    parameter int EV_LINES = EV_W,
    parameter int DEPTH    = FIFO_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       ctl_wr,
    input  logic [CTL_W-1:0]           ctl_wdata,
    input  logic                       cmd_wr,
    input  logic [CMD_W-1:0]           cmd_wdata,
    input  logic                       ext_pin,
    input  logic [EV_LINES-1:0]        ev_trig,
    output logic [N_UNITS-1:0]         conv_start,
    output logic [N_UNITS-1:0]         conv_busy,
    output logic [N_UNITS*CH_W-1:0]    conv_ch,
    input  logic [N_UNITS-1:0]         conv_done,
    input  logic [N_UNITS*RES_W-1:0]   conv_data,
    input  logic [N_UNITS-1:0]         rd_pop,
    output logic [N_UNITS*RES_W-1:0]   rd_data,
    output logic [N_UNITS-1:0]         rd_empty,
    output logic [N_UNITS-1:0]         ovf,
    output logic                       int_flag,
    output logic                       irq
);

    ctl_t               act;
    logic               trig;
    logic [N_UNITS-1:0] push;

    dconv_trig #(.EV_LINES(EV_LINES)) u_trig (
        .clk     (clk),
        .rst     (rst),
        .ext_pin (ext_pin),
        .ev_trig (ev_trig),
        .sw_req  (cmd_wr && cmd_wdata[CMD_START]),
        .ctl     (act),
        .trig    (trig)
    );

    dconv_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .ctl_wr     (ctl_wr),
        .ctl_wdata  (ctl_t'(ctl_wdata)),
        .trig       (trig),
        .clr_int    (cmd_wr && cmd_wdata[CMD_CLR_INT]),
        .conv_done  (conv_done),
        .act        (act),
        .conv_start (conv_start),
        .busy       (conv_busy),
        .push       (push),
        .int_flag   (int_flag),
        .irq        (irq)
    );

    assign conv_ch = {act.ch1, act.ch0};

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        dconv_fifo #(.WIDTH(RES_W), .DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst       (rst),
            .push      (push[u]),
            .push_data (conv_data[u*RES_W +: RES_W]),
            .pop       (rd_pop[u]),
            .clr_ovf   (cmd_wr && cmd_wdata[CMD_CLR_OVF0 + u]),
            .rd_data   (rd_data[u*RES_W +: RES_W]),
            .rd_empty  (rd_empty[u]),
            .ovf       (ovf[u])
        );
    end

endmodule

// File: tb/dual_conv_ctrl_tb.sv
module dual_conv_ctrl_tb;

    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 1'b0;
    logic [14:0] ctl_wdata = '0;
    logic        cmd_wr = 1'b0;
    logic [3:0]  cmd_wdata = '0;
    logic        ext_pin = 1'b0;
    logic [3:0]  ev_trig = '0;
    logic [1:0]  conv_start, conv_busy, conv_done, rd_pop, rd_empty, ovf;
    logic [5:0]  conv_ch;
    logic [19:0] conv_data, rd_data;
    logic        int_flag, irq;
    logic [1:0]  inj_done = '0;

    logic [3:0]  lat_q [2];
    logic [5:0]  seq_q [2];
    int          st_cnt [2];
    int          n_tests = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    dual_conv_ctrl u_dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .ext_pin(ext_pin), .ev_trig(ev_trig),
        .conv_start(conv_start), .conv_busy(conv_busy), .conv_ch(conv_ch),
        .conv_done(conv_done), .conv_data(conv_data), .rd_pop(rd_pop),
        .rd_data(rd_data), .rd_empty(rd_empty), .ovf(ovf),
        .int_flag(int_flag), .irq(irq)
    );

    // converter stubs: fixed latency, restart on a new start
    always @(posedge clk) begin
        for (int u = 0; u < 2; u++) begin
            if (rst) begin
                lat_q[u] <= '0;
                seq_q[u] <= '0;
                st_cnt[u] <= 0;
            end else begin
                if (conv_start[u]) st_cnt[u] <= st_cnt[u] + 1;
                if (conv_start[u]) lat_q[u] <= 4'(LAT);
                else if (lat_q[u] != 0) begin
                    lat_q[u] <= lat_q[u] - 1'b1;
                    if (lat_q[u] == 1) seq_q[u] <= seq_q[u] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        for (int u = 0; u < 2; u++) begin
            conv_done[u] = (lat_q[u] == 4'd1) | inj_done[u];
            conv_data[u*10 +: 10] = {u[0], conv_ch[u*3 +: 3], seq_q[u]};
        end
    end

    function automatic logic [14:0] mk(int ch0, int ch1, bit cont, bit imm, bit ie,
                                       bit fall, bit sw, bit ext, bit ev, bit u0, bit u1);
        return {u1, u0, ev, ext, sw, fall, ie, imm, cont, 3'(ch1), 3'(ch0)};
    endfunction

    function automatic int expd(int u, int ch, int s);
        return int'({u[0], 3'(ch), 6'(s)});
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input logic [14:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmd(input logic [3:0] v);
        @(negedge clk); cmd_wr = 1'b1; cmd_wdata = v;
        @(negedge clk); cmd_wr = 1'b0; cmd_wdata = '0;
    endtask

    task automatic pop(input int u);
        @(negedge clk); rd_pop[u] = 1'b1;
        @(negedge clk); rd_pop = '0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (conv_busy == 2'b00) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic drain();
        wait_idle();
        for (int i = 0; i < 3; i++) begin pop(0); pop(1); end
        cmd(4'b1110);
    endtask

    task automatic t_reset();
        chk(conv_start == 0, "R1 start", int'(conv_start), 0);
        chk(conv_busy == 0, "R1 busy", int'(conv_busy), 0);
        chk(rd_empty == 2'b11, "R1 empty", int'(rd_empty), 3);
        chk(ovf == 0 && int_flag == 0 && irq == 0, "R1 flags",
            int'({ovf, int_flag, irq}), 0);
    endtask

    task automatic t_sw_start();
        int s0;
        s0 = seq_q[0];
        wr_ctl(mk(5, 2, 0, 0, 1, 0, 1, 0, 0, 1, 1));
        cmd(4'b0001);
        chk(conv_start == 2'b11, "R2 start both", int'(conv_start), 3);
        chk(conv_ch == {3'd2, 3'd5}, "R2 channels", int'(conv_ch), 21);
        wait_idle();
        chk(int_flag == 1'b1, "R10 flag set", int'(int_flag), 1);
        chk(irq == 1'b1, "R10 irq enabled", int'(irq), 1);
        pop(0);
        chk(int'(rd_data[9:0]) == expd(0, 5, s0), "R4 unit0 data", int'(rd_data[9:0]), expd(0, 5, s0));
        pop(0);
        chk(rd_empty[0] && int'(rd_data[9:0]) == expd(0, 5, s0), "R4 empty read",
            int'(rd_data[9:0]), expd(0, 5, s0));
        cmd(4'b0010);
        chk(int_flag == 0 && irq == 0, "R10 flag clear", int'({int_flag, irq}), 0);
        drain();
    endtask

    task automatic t_overflow();
        int s0;
        wr_ctl(mk(3, 6, 0, 0, 0, 0, 1, 0, 0, 1, 1));
        s0 = seq_q[0];
        for (int k = 0; k < 3; k++) begin cmd(4'b0001); wait_idle(); end
        chk(ovf == 2'b11, "R5 overflow set", int'(ovf), 3);
        chk(int_flag == 1 && irq == 0, "R10 irq masked", int'({int_flag, irq}), 2);
        pop(0);
        chk(int'(rd_data[9:0]) == expd(0, 3, s0), "R5 oldest kept", int'(rd_data[9:0]), expd(0, 3, s0));
        pop(0);
        chk(int'(rd_data[9:0]) == expd(0, 3, s0 + 1), "R4 second entry",
            int'(rd_data[9:0]), expd(0, 3, s0 + 1));
        pop(0);
        chk(rd_empty[0] && int'(rd_data[9:0]) == expd(0, 3, s0 + 1), "R5 third dropped",
            int'(rd_data[9:0]), expd(0, 3, s0 + 1));
        chk(ovf == 2'b11, "R5 sticky", int'(ovf), 3);
        cmd(4'b0100);
        chk(ovf == 2'b10, "R5 clear unit0", int'(ovf), 2);
        cmd(4'b1000);
        chk(ovf == 2'b00, "R5 clear unit1", int'(ovf), 0);
        drain();
    endtask

    task automatic t_continuous();
        int c0;
        wr_ctl(mk(3, 0, 1, 0, 0, 0, 1, 0, 0, 1, 0));
        c0 = st_cnt[0];
        cmd(4'b0001);
        repeat (40) @(negedge clk);
        chk(st_cnt[0] - c0 >= 3, "R3 continuous restarts", st_cnt[0] - c0, 3);
        wr_ctl(mk(3, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
        repeat (20) @(negedge clk);
        c0 = st_cnt[0];
        repeat (40) @(negedge clk);
        chk(st_cnt[0] == c0, "R3 stops when cleared", st_cnt[0] - c0, 0);
        drain();
        c0 = st_cnt[0];
        cmd(4'b0001);
        repeat (40) @(negedge clk);
        chk(st_cnt[0] - c0 == 1, "R3 single round", st_cnt[0] - c0, 1);
        drain();
    endtask

    task automatic t_shadow();
        wr_ctl(mk(1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
        cmd(4'b0001);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = mk(6, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0);
        @(negedge clk); ctl_wr = 1'b0;
        chk(conv_busy[0] == 1 && conv_ch[2:0] == 3'd1, "R6 held while busy",
            int'(conv_ch[2:0]), 1);
        wait_idle();
        chk(conv_ch[2:0] == 3'd6, "R6 applied when idle", int'(conv_ch[2:0]), 6);
        pop(0);
        chk(rd_data[8:6] == 3'd1, "R6 result channel", int'(rd_data[8:6]), 1);
        drain();
    endtask

    task automatic t_policy();
        int c0;
        wr_ctl(mk(2, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0));
        c0 = st_cnt[0];
        cmd(4'b0001);
        cmd(4'b0001);
        chk(conv_start[0] == 0, "R7 hold no start", int'(conv_start[0]), 0);
        wait_idle();
        wait_idle();
        chk(st_cnt[0] - c0 == 2, "R7 held start runs", st_cnt[0] - c0, 2);
        pop(0); pop(0);
        chk(rd_empty[0] == 1'b1, "R7 two results", int'(rd_empty[0]), 1);
        drain();
        wr_ctl(mk(2, 0, 0, 1, 0, 0, 1, 0, 0, 1, 0));
        c0 = st_cnt[0];
        cmd(4'b0001);
        cmd(4'b0001);
        chk(conv_start[0] == 1, "R7 immediate restart", int'(conv_start[0]), 1);
        wait_idle();
        chk(st_cnt[0] - c0 == 2, "R7 immediate count", st_cnt[0] - c0, 2);
        pop(0);
        pop(0);
        chk(rd_empty[0] == 1'b1, "R7 aborted no result", int'(rd_empty[0]), 1);
        drain();
    endtask

    task automatic t_pin();
        int c1;
        wr_ctl(mk(0, 4, 0, 0, 0, 0, 0, 1, 0, 0, 1));
        c1 = st_cnt[1];
        @(negedge clk); ext_pin = 1'b1;
        repeat (8) @(negedge clk);
        chk(st_cnt[1] - c1 == 1, "R8 rising edge", st_cnt[1] - c1, 1);
        wait_idle();
        @(negedge clk); ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        chk(st_cnt[1] - c1 == 1, "R8 falling ignored", st_cnt[1] - c1, 1);
        wr_ctl(mk(0, 4, 0, 0, 0, 1, 0, 1, 0, 0, 1));
        @(negedge clk); ext_pin = 1'b1;
        repeat (12) @(negedge clk);
        chk(st_cnt[1] - c1 == 1, "R8 rising ignored", st_cnt[1] - c1, 1);
        @(negedge clk); ext_pin = 1'b0;
        repeat (8) @(negedge clk);
        chk(st_cnt[1] - c1 == 2, "R8 falling edge", st_cnt[1] - c1, 2);
        wait_idle();
        wr_ctl(mk(0, 4, 0, 0, 0, 0, 0, 0, 0, 0, 1));
        @(negedge clk); ext_pin = 1'b1;
        repeat (8) @(negedge clk); ext_pin = 1'b0;
        repeat (8) @(negedge clk);
        chk(st_cnt[1] - c1 == 2, "R8 disabled pin", st_cnt[1] - c1, 2);
        drain();
    endtask

    task automatic t_events();
        int c0;
        wr_ctl(mk(7, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1));
        @(negedge clk); ev_trig = 4'b0100;
        @(negedge clk); ev_trig = '0;
        chk(conv_start == 2'b11, "R9 event start", int'(conv_start), 3);
        drain();
        wr_ctl(mk(7, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1));
        c0 = st_cnt[0];
        @(negedge clk); ev_trig = 4'b0001;
        @(negedge clk); ev_trig = '0;
        cmd(4'b0001);
        repeat (15) @(negedge clk);
        chk(st_cnt[0] == c0, "R9 R2 disabled sources", st_cnt[0] - c0, 0);
        drain();
    endtask

    task automatic t_stray();
        @(negedge clk); inj_done = 2'b01;
        @(negedge clk); inj_done = '0;
        repeat (2) @(negedge clk);
        chk(rd_empty[0] == 1'b1, "R11 no push", int'(rd_empty[0]), 1);
        chk(int_flag == 1'b0, "R11 no flag", int'(int_flag), 0);
    endtask

    initial begin
        rd_pop = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_sw_start();
        t_overflow();
        t_continuous();
        t_shadow();
        t_policy();
        t_pin();
        t_events();
        t_stray();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule